// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers error indications from a four-channel audio converter and presents them to a host. The error sources are four ADC overflow levels, four DAC clip levels and one combined clocking-error level. A rising edge on any source sets a sticky notification bit. The bit stays set after the source falls, and it is cleared only when the host reads its notification register. Each notification bit has a mask bit. A set mask stops that bit from asserting the interrupt pin, but the bit itself is still recorded.

The host reaches five 8-bit registers through a plain single-cycle read/write port. Read data is combinational from the addressed register. A read strobe on a notification address returns that register and clears it at the same clock edge. In the default interrupt mode, that read also sets the mask bit of every error it returned, so one error raises the pin only once until software unmasks it. A control register selects the active level of the pin, push-pull or open-drain drive, and whether auto-masking is on. The interrupt output is a drive value plus an output enable, so the pad can share a wired line.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every notification and mask bit and the control register read 0. With control 0 the pin is active-low and push-pull, so irq_o=1 and irq_oe=1.
- R2: A 0-to-1 change of a source sets its notification bit at the next clock edge. A source held high after its bit was cleared does not set it again.
- R3: A set notification bit stays set after its source returns low, until its register is read.
- R4: A read strobe on a notification address returns the pre-clear contents and clears the register at that edge. A source edge arriving in the same cycle leaves its bit set.
- R5: With control bit 2 = 0 (auto-mask), a read of a notification register ORs the bits it returned into the matching mask register. No other mask bit changes.
- R6: With control bit 2 = 1 (manual), reads leave both mask registers unchanged.
- R7: A notification bit whose mask bit is 1 is still latched but does not assert the pin.
- R8: The pin is active while any notification bit with a clear mask bit is set. Control bit 0 selects the active level: 1 means active high, 0 means active low. When the pin is inactive it drives the opposite level.
- R9: With control bit 1 = 1 (open-drain), irq_oe is 1 only while the pin is active. With control bit 1 = 0 (push-pull), irq_oe is always 1.
- R10: Register map:
  - Address 0 is control, bits [2:0].
  - Address 1 is the mask for ADC overflows in bits [3:0] (channel 0 in bit 0) and the clocking error in bit 7.
  - Address 2 is the mask for DAC clips in bits [3:0].
  - Addresses 3 and 4 are the notification registers, with the same bit positions as addresses 1 and 2.
  - Unused bits and unmapped addresses read 0.
  - Writes to addresses 3 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_ovfl | input | 4 | ADC overflow levels, one per channel |
| dac_clip | input | 4 | DAC clip levels, one per channel |
| clk_err | input | 1 | Combined clocking error level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears notification registers) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt drive level |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The bench targets the following corner cases:
- A source edge that lands in the same cycle as a read of its register. A design that cleared after merging would lose that event.
- A source held high across a read. A level-sensitive design would re-latch it at once.
- Auto-masking must cover only the bits actually returned. A design that masked the whole register would silence the new event.
- A manual-mode read. A wrong design would still touch the masks.
- Writes to notification addresses and to unused mask bits. A wrong design would corrupt state or read back phantom bits.
- The pin under every polarity and drive setting. A design that kept the output enable on in open-drain idle would hold a shared line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NGRP   = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK_A = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK_B = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_NOTE_A = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_NOTE_B = 3'd4;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_POL    = 0;
  localparam int unsigned CTL_OD     = 1;
  localparam int unsigned CTL_MANUAL = 2;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_i,
  output logic [W-1:0] note_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;

  assign rise = lvl_i & ~prev_q & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      note_o <= '0;
    end else begin
      prev_q <= lvl_i & VALID;
      // clear first, then merge this cycle's edges so none is lost
      note_o <= (clr_i ? '0 : note_o) | rise;
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] auto_set_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & VALID;
    else           mask_o <= mask_o | (auto_set_i & VALID);
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic active_i,
  input  logic pol_i,
  input  logic od_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    pin_o = active_i ? pol_i : ~pol_i;
    oe_o  = od_i ? active_i : 1'b1;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_ADC = 4,
  parameter int unsigned N_DAC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ADC-1:0]  adc_ovfl,
  input  logic [N_DAC-1:0]  dac_clip,
  input  logic              clk_err,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam logic [REG_W-1:0] VALID_A =
    REG_W'((1 << N_ADC) - 1) | (REG_W'(1) << (REG_W - 1));
  localparam logic [REG_W-1:0] VALID_B = REG_W'((1 << N_DAC) - 1);

  logic [CTL_W-1:0]            ctrl_q;
  logic [NGRP-1:0][REG_W-1:0]  src;
  logic [NGRP-1:0][REG_W-1:0]  note_q;
  logic [NGRP-1:0][REG_W-1:0]  mask_q;
  logic [NGRP-1:0]             grp_hit;
  logic                        irq_any;

  always_comb begin
    src = '0;
    src[0][N_ADC-1:0] = adc_ovfl;
    src[0][REG_W-1]   = clk_err;
    src[1][N_DAC-1:0] = dac_clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= reg_wdata[CTL_W-1:0];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [REG_W-1:0] VMASK = (g == 0) ? VALID_A : VALID_B;
    logic             rd_note;
    logic             wr_mask;
    logic [REG_W-1:0] auto_set;

    assign rd_note  = reg_rd && (reg_addr == ADR_NOTE_A + ADDR_W'(g));
    assign wr_mask  = reg_wr && (reg_addr == ADR_MASK_A + ADDR_W'(g));
    assign auto_set = (rd_note && !ctrl_q[CTL_MANUAL]) ? note_q[g] : '0;

    irq_edge_latch #(.W(REG_W), .VALID(VMASK)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (src[g]),
      .clr_i (rd_note),
      .note_o(note_q[g])
    );

    irq_mask_bank #(.W(REG_W), .VALID(VMASK)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_mask),
      .wdata_i   (reg_wdata),
      .auto_set_i(auto_set),
      .mask_o    (mask_q[g])
    );

    assign grp_hit[g] = |(note_q[g] & ~mask_q[g]);
  end

  assign irq_any = |grp_hit;

  always_comb begin
    case (reg_addr)
      ADR_CTRL:   reg_rdata = REG_W'(ctrl_q);
      ADR_MASK_A: reg_rdata = mask_q[0];
      ADR_MASK_B: reg_rdata = mask_q[1];
      ADR_NOTE_A: reg_rdata = note_q[0];
      ADR_NOTE_B: reg_rdata = note_q[1];
      default:    reg_rdata = '0;
    endcase
  end

  irq_pin_drive u_pin (
    .active_i(irq_any),
    .pol_i   (ctrl_q[CTL_POL]),
    .od_i    (ctrl_q[CTL_OD]),
    .pin_o   (irq_o),
    .oe_o    (irq_oe)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clk_err,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq_o,
  input logic              irq_oe,
  input logic [CTL_W-1:0]  ctrl,
  input logic [REG_W-1:0]  mask_a,
  input logic [REG_W-1:0]  mask_b,
  input logic [REG_W-1:0]  note_a,
  input logic [REG_W-1:0]  note_b
);
  // R2
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |=> note_a[REG_W-1]);

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == ADR_NOTE_A) |=> ((note_a & $past(note_a)) == $past(note_a)));

  // R5
  auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_NOTE_A && !ctrl[CTL_MANUAL])
      |=> ((mask_a & $past(note_a)) == $past(note_a)));

  // R6
  manual_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTL_MANUAL] && !reg_wr) |=> ($stable(mask_a) && $stable(mask_b)));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((note_a & ~mask_a) == '0) && ((note_b & ~mask_b) == '0)) |-> (irq_o != ctrl[CTL_POL]));

  // R8
  pin_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((note_a & ~mask_a) != '0) || ((note_b & ~mask_b) != '0)) |-> (irq_o == ctrl[CTL_POL]));

  // R9
  od_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[CTL_OD] |-> (irq_oe == (irq_o == ctrl[CTL_POL])));

  // R9
  pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTL_OD] |-> irq_oe);
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_err (clk_err),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .reg_addr(reg_addr),
  .irq_o   (irq_o),
  .irq_oe  (irq_oe),
  .ctrl    (ctrl_q),
  .mask_a  (mask_q[0]),
  .mask_b  (mask_q[1]),
  .note_a  (note_q[0]),
  .note_b  (note_q[1])
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] adc_ovfl = '0;
  logic [3:0] dac_clip = '0;
  logic       clk_err = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  logic       irq_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .adc_ovfl(adc_ovfl), .dac_clip(dac_clip),
    .clk_err(clk_err), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // entry: {req, src{clk_err,dac[3:0],adc[3:0]}, wr, rd, addr, wdata, exp_rdata, exp_irq, exp_oe}
  localparam int NV = 27;
  localparam logic [35:0] VEC [NV] = '{
    {4'd1,  9'h000, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b1}, // R1 clean state
    {4'd2,  9'h001, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b1}, // R2 adc0 rises
    {4'd2,  9'h001, 1'b0, 1'b0, 3'd3, 8'h00, 8'h01, 1'b0, 1'b1}, // R2 latched, R8 low active
    {4'd3,  9'h000, 1'b0, 1'b0, 3'd3, 8'h00, 8'h01, 1'b0, 1'b1}, // R3 source gone, bit held
    {4'd4,  9'h000, 1'b0, 1'b1, 3'd3, 8'h00, 8'h01, 1'b0, 1'b1}, // R4 read returns content
    {4'd5,  9'h000, 1'b0, 1'b0, 3'd1, 8'h00, 8'h01, 1'b1, 1'b1}, // R5 auto-mask set
    {4'd2,  9'h001, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b1}, // R4 cleared, new edge
    {4'd7,  9'h001, 1'b0, 1'b0, 3'd3, 8'h00, 8'h01, 1'b1, 1'b1}, // R7 latched but masked
    {4'd10, 9'h000, 1'b1, 1'b0, 3'd0, 8'h04, 8'h00, 1'b1, 1'b1}, // R10 ctrl manual
    {4'd10, 9'h000, 1'b1, 1'b0, 3'd1, 8'h00, 8'h01, 1'b1, 1'b1}, // R10 unmask
    {4'd8,  9'h040, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 1'b1}, // R8 unmasked bit drives
    {4'd10, 9'h040, 1'b0, 1'b1, 3'd4, 8'h00, 8'h04, 1'b0, 1'b1}, // R10 dac2 in bit 2
    {4'd6,  9'h000, 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 1'b0, 1'b1}, // R6 mask B untouched
    {4'd4,  9'h000, 1'b0, 1'b1, 3'd3, 8'h00, 8'h01, 1'b0, 1'b1}, // R4 read clears A
    {4'd6,  9'h000, 1'b0, 1'b0, 3'd1, 8'h00, 8'h00, 1'b1, 1'b1}, // R6 mask A untouched
    {4'd8,  9'h000, 1'b1, 1'b0, 3'd0, 8'h05, 8'h04, 1'b1, 1'b1}, // R8 set active-high
    {4'd8,  9'h000, 1'b0, 1'b0, 3'd0, 8'h00, 8'h05, 1'b0, 1'b1}, // R8 inactive low
    {4'd9,  9'h000, 1'b1, 1'b0, 3'd0, 8'h07, 8'h05, 1'b0, 1'b1}, // R9 go open-drain
    {4'd9,  9'h100, 1'b0, 1'b0, 3'd0, 8'h00, 8'h07, 1'b0, 1'b0}, // R9 idle, oe off
    {4'd9,  9'h100, 1'b0, 1'b0, 3'd3, 8'h00, 8'h80, 1'b1, 1'b1}, // R9 active, R10 bit7
    {4'd10, 9'h000, 1'b1, 1'b0, 3'd3, 8'hFF, 8'h80, 1'b1, 1'b1}, // R10 write note ignored
    {4'd10, 9'h000, 1'b0, 1'b0, 3'd3, 8'h00, 8'h80, 1'b1, 1'b1}, // R10 still 80
    {4'd10, 9'h000, 1'b1, 1'b0, 3'd1, 8'hFF, 8'h00, 1'b1, 1'b1}, // R10 write all ones
    {4'd10, 9'h000, 1'b0, 1'b0, 3'd1, 8'h00, 8'h8F, 1'b0, 1'b0}, // R10 valid bits only, R7
    {4'd8,  9'h000, 1'b1, 1'b0, 3'd0, 8'h00, 8'h07, 1'b0, 1'b0}, // R8 back to defaults
    {4'd8,  9'h000, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R8 active-low idle
    {4'd10, 9'h000, 1'b0, 1'b0, 3'd5, 8'h00, 8'h00, 1'b1, 1'b1}  // R10 unmapped reads 0
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_step(input int req, input logic [8:0] s, input logic w, input logic r,
                         input logic [2:0] a, input logic [7:0] wd, input logic [7:0] ed,
                         input logic ei, input logic eo);
    @(negedge clk);
    adc_ovfl = s[3:0]; dac_clip = s[7:4]; clk_err = s[8];
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
    #1;
    chk(req, "rdata", reg_rdata, ed);
    chk(req, "irq_o", {7'd0, irq_o}, {7'd0, ei});
    chk(req, "irq_oe", {7'd0, irq_oe}, {7'd0, eo});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      do_step(int'(VEC[i][35:32]), VEC[i][31:23], VEC[i][22], VEC[i][21], VEC[i][20:18],
              VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end
    // R4 corner: edge on adc1 during a read of its register
    do_step(4, 9'h000, 1'b1, 1'b0, 3'd1, 8'h00, 8'h8F, 1'b1, 1'b1);
    do_step(4, 9'h002, 1'b0, 1'b1, 3'd3, 8'h00, 8'h80, 1'b0, 1'b1);
    do_step(4, 9'h002, 1'b0, 1'b0, 3'd3, 8'h00, 8'h02, 1'b0, 1'b1);
    // R5 only the bits read (bit 7) got masked
    do_step(5, 9'h002, 1'b0, 1'b0, 3'd1, 8'h00, 8'h80, 1'b0, 1'b1);
    // R2 level held across a clearing read does not re-latch
    do_step(2, 9'h002, 1'b0, 1'b1, 3'd3, 8'h00, 8'h02, 1'b0, 1'b1);
    do_step(2, 9'h002, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b1);
    // R1 reset from a busy state
    do_step(8, 9'h010, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b1, 1'b1);
    do_step(8, 9'h000, 1'b0, 1'b0, 3'd4, 8'h00, 8'h01, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      do_step(1, 9'h000, 1'b0, 1'b0, 3'(a), 8'h00, 8'h00, 1'b1, 1'b1); // R1
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule